// File: doc/BRIEF.md
# Carry-reduced lookahead adder

This block is a purely combinational n-bit adder in lookahead form that is allowed to be wrong. A per-bit stage forms propagate and generate terms, and a carry generator builds each carry only from a bounded window of the nearest lower bit positions. A carry that would have to travel further than that window is dropped on purpose. Inputs where that happens always give the same wrong sum; it never depends on chance. In exchange, each carry needs fewer terms and less logic depth than in a full lookahead adder.

It suits datapaths that tolerate a small, controlled error rate and check any result that matters afterwards. Hash-search pipelines are one example, because their operands behave like uniform random values. The parameter `SPAN` sets the window. Setting `SPAN` equal to `WIDTH` gives an exact adder. A two-level form splits the word into groups. Each group has its own window, and the carries between groups pass through a second, truncated generator with a window of `GRP_SPAN` groups. An optional output compares the result with the exact sum so that a bench can measure the error rate.

Top module: `cra_adder`

## Requirements
- R1: For every bit i, `sum_o[i]` = `a_i[i]` ^ `b_i[i]` ^ carry(i). The carry into bit 0 is the carry-in. Propagate is a XOR b and generate is a AND b. When `a_i & b_i` is zero and the carry-in is 0 or disabled, `sum_o` equals `a_i | b_i`.
- R2: In flat mode (`HIER`=0), the carry into bit i is formed only from propagate and generate of bits max(0,i-SPAN) to i-1. The carry-in contributes only when i <= SPAN. As a result, the lowest min(SPAN+1,WIDTH) bits of `sum_o` always match the exact sum.
- R3: With `SPAN` = `WIDTH` in flat mode, `sum_o` equals (a_i + b_i + cin) mod 2^WIDTH for all inputs.
- R4: With WIDTH=32 and SPAN=13, 0xFFFFFFFF + 0x00000001 (carry-in 0) gives 0xFFFFC000 every time it is applied, and 0xFFFFFFFF + 0 with carry-in 1 also gives 0xFFFFC000.
- R5: No carry out of the top bit is produced. The sum wraps modulo 2^WIDTH, so 0x80000000 + 0x80000000 gives 0 on an exact configuration.
- R6: With `CIN_EN`=0, `cin_i` has no effect on `sum_o` or `mismatch_o`.
- R7: With `CHECK_EN`=1, `mismatch_o` is 1 exactly when `sum_o` differs from (a_i + b_i + effective carry-in) mod 2^WIDTH.
- R8: In two-level mode (`HIER`=1), the word is split into WIDTH/GRP groups. The group carry into group m is built from the group generate and group propagate of groups max(0,m-GRP_SPAN) to m-1, plus the carry-in when m <= GRP_SPAN. Group generate is the truncated carry out of the group with zero carry-in. Group propagate is the AND of the group's propagates. Inside a group, the carry into offset t uses the window rule of R2 with bound `SPAN`, clipped at the group base. The group carry enters at offset t only when t <= SPAN. With GRP=8, SPAN=8 and GRP_SPAN=2, 0xFFFFFFFF + 1 gives 0xFF000000.
- R9: With WIDTH=32 and SPAN=13, uniformly random operands and carry-in give a mismatch rate of a few hundredths of a percent (at most 40 mismatches in 20000 vectors).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in, used only when CIN_EN=1 |
| sum_o | output | WIDTH | Truncated-carry sum, no carry-out |
| mismatch_o | output | 1 | 1 when sum_o differs from the exact sum (0 when CHECK_EN=0) |

## Verification
Two effects can land in the same evaluation: the carry-in reaching a bit through the window, and a generate from inside the operands reaching the same bit. They can also collide with a chain that is cut off at the window edge. The bench provokes this with all-ones operands plus a carry-in, and with chains whose length is exactly SPAN and SPAN+1, shifted away from bit 0. It judges every instance on every clock against a windowed-slice reference model and against the exact sum. In two-level mode, the group carry and an in-group generate can also meet at one bit. That case is covered by directed all-ones patterns and by 20000 random vectors.

// File: rtl/cra_pkg.sv
package cra_pkg;
  function automatic int min_int(input int x, input int y);
    return (x < y) ? x : y;
  endfunction
endpackage

// File: rtl/cra_pg_stage.sv
module cra_pg_stage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o,
  output logic [WIDTH-1:0] g_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    assign g_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/cra_lookahead.sv
// Truncated carry generator: c_o[i] is the carry into position i, built from
// at most SPAN positions directly below it; c_o[N] is the carry out of N-1.
module cra_lookahead #(
  parameter int N    = 8,
  parameter int SPAN = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         cin_i,
  output logic [N:0]   c_o
);
  assign c_o[0] = cin_i;

  for (genvar i = 1; i <= N; i++) begin : g_carry
    logic bit_c;
    always_comb begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int d = 1; d <= N; d++) begin
        if (d <= SPAN && d <= i) begin
          acc = acc | (run & g_i[i-d]);
          run = run & p_i[i-d];
        end
      end
      // carry-in is visible only if the window reaches position 0
      if (i <= SPAN) acc = acc | (run & cin_i);
      bit_c = acc;
    end
    assign c_o[i] = bit_c;
  end
endmodule

// File: rtl/cra_adder.sv
module cra_adder
  import cra_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int SPAN     = 13,
  parameter bit CIN_EN   = 1'b1,
  parameter bit HIER     = 1'b0,
  parameter int GRP      = 8,
  parameter int GRP_SPAN = 2,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             mismatch_o
);
  localparam int NG = WIDTH / GRP;

  // elaboration-time parameter checks
  if (WIDTH < 2) begin : g_bad_width
    $error("cra_adder: WIDTH must be at least 2");
  end
  if (SPAN < 1 || SPAN > WIDTH) begin : g_bad_span
    $error("cra_adder: SPAN must lie in 1..WIDTH");
  end
  if (HIER) begin : g_hier_chk
    if (GRP < 2 || (WIDTH % GRP) != 0 || NG < 2) begin : g_bad_grp
      $error("cra_adder: GRP must divide WIDTH into at least two groups of two bits");
    end
    if (GRP_SPAN < 1 || GRP_SPAN > NG) begin : g_bad_gspan
      $error("cra_adder: GRP_SPAN must lie in 1..WIDTH/GRP");
    end
  end

  logic [WIDTH-1:0] p;
  logic [WIDTH-1:0] g;
  logic [WIDTH-1:0] c;
  logic             cin_eff;

  assign cin_eff = CIN_EN ? cin_i : 1'b0;

  cra_pg_stage #(.WIDTH(WIDTH)) u_pg (
    .a_i(a_i),
    .b_i(b_i),
    .p_o(p),
    .g_o(g)
  );

  if (!HIER) begin : g_flat
    cra_lookahead #(.N(WIDTH-1), .SPAN(SPAN)) u_cg (
      .p_i  (p[WIDTH-2:0]),
      .g_i  (g[WIDTH-2:0]),
      .cin_i(cin_eff),
      .c_o  (c)
    );
  end else begin : g_two_level
    logic [NG-1:0] gc;
    logic [NG-2:0] gp;
    logic [NG-2:0] gg;

    cra_lookahead #(.N(NG-1), .SPAN(GRP_SPAN)) u_upper (
      .p_i  (gp),
      .g_i  (gg),
      .cin_i(cin_eff),
      .c_o  (gc)
    );

    for (genvar m = 0; m < NG; m++) begin : g_grp
      localparam int  BASE = m * GRP;
      localparam bit  LAST = (m == NG - 1);
      localparam int  NL   = LAST ? GRP - 1 : GRP;
      localparam int  WIN  = min_int(SPAN, GRP);
      logic [NL:0] cl;

      cra_lookahead #(.N(NL), .SPAN(WIN)) u_lower (
        .p_i  (p[BASE+NL-1:BASE]),
        .g_i  (g[BASE+NL-1:BASE]),
        .cin_i(1'b0),
        .c_o  (cl)
      );

      if (!LAST) begin : g_gpg
        assign gg[m] = cl[GRP];
        assign gp[m] = &p[BASE+GRP-1:BASE];
      end

      for (genvar t = 0; t < GRP; t++) begin : g_off
        if (t <= SPAN) begin : g_reach
          logic run;
          always_comb begin
            run = 1'b1;
            for (int k = 0; k < GRP; k++) begin
              if (k < t) run = run & p[BASE+k];
            end
          end
          assign c[BASE+t] = cl[t] | (gc[m] & run);
        end else begin : g_local
          assign c[BASE+t] = cl[t];
        end
      end
    end
  end

  assign sum_o = p ^ c;

  if (CHECK_EN) begin : g_check
    logic [WIDTH-1:0] exact;
    assign exact      = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_eff};
    assign mismatch_o = (sum_o != exact);
  end else begin : g_nocheck
    assign mismatch_o = 1'b0;
  end
endmodule

// File: rtl/cra_adder_chk.sv
module cra_adder_chk #(
  parameter int WIDTH  = 32,
  parameter int SPAN   = 13,
  parameter bit CIN_EN = 1'b1,
  parameter bit HIER   = 1'b0
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o
);
  localparam int LOWN = (SPAN + 1 > WIDTH) ? WIDTH : SPAN + 1;

  logic             cin_eff;
  logic [WIDTH-1:0] exact;
  logic [WIDTH-1:0] low_mask;

  assign cin_eff  = CIN_EN ? cin_i : 1'b0;
  assign exact    = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_eff};
  assign low_mask = {WIDTH{1'b1}} >> (WIDTH - LOWN);

  always_comb begin
    AST_LSB_EXACT: assert (sum_o[0] == (a_i[0] ^ b_i[0] ^ cin_eff))
      else $error("lsb wrong"); // R1
    if ((a_i & b_i) == '0 && !cin_eff) begin
      AST_NO_GEN_EXACT: assert (sum_o == (a_i | b_i))
        else $error("no-generate sum wrong"); // R1
    end
    if (!HIER) begin
      AST_LOW_BITS_EXACT: assert (((sum_o ^ exact) & low_mask) == '0)
        else $error("low window bits wrong"); // R2
      if (SPAN >= WIDTH) begin
        AST_FULL_SPAN_EXACT: assert (sum_o == exact)
          else $error("full span not exact"); // R3
      end
    end
    if (!CIN_EN) begin
      AST_CIN_IGNORED: assert (sum_o[0] == (a_i[0] ^ b_i[0]))
        else $error("carry-in leaked"); // R6
    end
  end
endmodule

bind cra_adder cra_adder_chk #(
  .WIDTH (WIDTH),
  .SPAN  (SPAN),
  .CIN_EN(CIN_EN),
  .HIER  (HIER)
) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .cin_i(cin_i),
  .sum_o(sum_o)
);

// File: tb/cra_adder_test.sv
`timescale 1ns/1ps
module cra_adder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic        cin = 1'b0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  logic [31:0] s_main, s_full, s_nocin, s_hier, s_hlo;
  logic        m_main, m_full, m_nocin, m_hier, m_hlo;

  cra_adder #(.WIDTH(32), .SPAN(13)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_main), .mismatch_o(m_main));
  cra_adder #(.WIDTH(32), .SPAN(32)) u_full (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_full), .mismatch_o(m_full));
  cra_adder #(.WIDTH(32), .SPAN(13), .CIN_EN(1'b0)) u_nocin (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_nocin), .mismatch_o(m_nocin));
  cra_adder #(.WIDTH(32), .SPAN(8), .HIER(1'b1), .GRP(8), .GRP_SPAN(2)) u_hier (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_hier), .mismatch_o(m_hier));
  cra_adder #(.WIDTH(32), .SPAN(3), .HIER(1'b1), .GRP(8), .GRP_SPAN(1)) u_hlo (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s_hlo), .mismatch_o(m_hlo));

  // carry out of slice [lo,hi) computed as a plain integer addition
  function automatic logic slice_carry(input logic [31:0] x, input logic [31:0] y,
                                       input logic ci, input int lo, input int hi);
    longint unsigned sx = 0, sy = 0, tot;
    for (int j = lo; j < hi; j++) begin
      sx = sx | (longint'(x[j]) << (j - lo));
      sy = sy | (longint'(y[j]) << (j - lo));
    end
    tot = sx + sy + longint'(ci);
    return tot[hi-lo];
  endfunction

  function automatic logic [31:0] flat_model(input logic [31:0] x, input logic [31:0] y,
                                             input logic ci, input int span);
    logic [31:0] s;
    for (int i = 0; i < 32; i++) begin
      int lo = (i - span > 0) ? i - span : 0;
      s[i] = x[i] ^ y[i] ^ slice_carry(x, y, (lo == 0) ? ci : 1'b0, lo, i);
    end
    return s;
  endfunction

  function automatic logic [31:0] hier_model(input logic [31:0] x, input logic [31:0] y,
                                             input logic ci, input int grp,
                                             input int span, input int gspan);
    logic [31:0] s;
    logic [31:0] ggen, gprop, gcar;
    int ng = 32 / grp;
    for (int j = 0; j < ng; j++) begin
      int base = j * grp;
      int lo = (grp - span > 0) ? base + grp - span : base;
      ggen[j]  = slice_carry(x, y, 1'b0, lo, base + grp);
      gprop[j] = 1'b1;
      for (int k = base; k < base + grp; k++) gprop[j] = gprop[j] & (x[k] ^ y[k]);
    end
    for (int m = 0; m < ng; m++) begin
      int lo = (m - gspan > 0) ? m - gspan : 0;
      logic cc = (lo == 0) ? ci : 1'b0;
      for (int j = lo; j < m; j++) cc = ggen[j] | (gprop[j] & cc);
      gcar[m] = cc;
    end
    for (int i = 0; i < 32; i++) begin
      int base = (i / grp) * grp;
      int lo = (i - span > base) ? i - span : base;
      s[i] = x[i] ^ y[i] ^ slice_carry(x, y, (lo == base) ? gcar[i/grp] : 1'b0, lo, i);
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] x, input logic [31:0] y, input logic ci);
    @(posedge clk);
    #1;
    a = x; b = y; cin = ci;
    @(negedge clk);
  endtask

  // full reference comparison of every instance, used on every vector
  task automatic compare_all();
    logic [31:0] ex  = a + b + {31'b0, cin};
    logic [31:0] ex0 = a + b;
    logic [31:0] e_main  = flat_model(a, b, cin, 13);
    logic [31:0] e_nocin = flat_model(a, b, 1'b0, 13);
    logic [31:0] e_hier  = hier_model(a, b, cin, 8, 8, 2);
    logic [31:0] e_hlo   = hier_model(a, b, cin, 8, 3, 1);
    chk(s_main == e_main, "R2 flat window", s_main, e_main);
    chk(s_full == ex, "R3 full span exact", s_full, ex);
    chk(s_nocin == e_nocin, "R6 cin ignored", s_nocin, e_nocin);
    chk(s_hier == e_hier, "R8 two-level full lower", s_hier, e_hier);
    chk(s_hlo == e_hlo, "R8 two-level truncated lower", s_hlo, e_hlo);
    chk(m_main == (e_main != ex), "R7 mismatch flag", {31'b0, m_main}, {31'b0, e_main != ex});
    chk(m_nocin == (e_nocin != ex0), "R7 mismatch flag no cin",
        {31'b0, m_nocin}, {31'b0, e_nocin != ex0});
    chk(m_hlo == (e_hlo != ex), "R7 mismatch flag two-level",
        {31'b0, m_hlo}, {31'b0, e_hlo != ex});
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int miss = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_main == 32'h0 && m_main == 1'b0, "R1 reset state", s_main, 32'h0);
    rst_ni = 1'b1;

    // R4: deterministic failure, applied twice
    drive(32'hFFFF_FFFF, 32'h1, 1'b0);
    chk(s_main == 32'hFFFF_C000, "R4 all-ones plus one", s_main, 32'hFFFF_C000);
    chk(m_main == 1'b1, "R7 flag on dropped carry", {31'b0, m_main}, 32'h1);
    chk(s_full == 32'h0, "R3 full span all-ones plus one", s_full, 32'h0);
    chk(s_hier == 32'hFF00_0000, "R8 two-level all-ones plus one", s_hier, 32'hFF00_0000);
    compare_all();
    drive(32'h0, 32'h0, 1'b0);
    drive(32'hFFFF_FFFF, 32'h1, 1'b0);
    chk(s_main == 32'hFFFF_C000, "R4 repeat gives same result", s_main, 32'hFFFF_C000);

    // carry-in and in-word chain meet
    drive(32'hFFFF_FFFF, 32'h0, 1'b1);
    chk(s_main == 32'hFFFF_C000, "R4 carry-in through all ones", s_main, 32'hFFFF_C000);
    chk(s_nocin == 32'hFFFF_FFFF, "R6 carry-in ignored", s_nocin, 32'hFFFF_FFFF);
    chk(m_nocin == 1'b0, "R6 flag unaffected by cin", {31'b0, m_nocin}, 32'h0);
    compare_all();

    drive(32'h5, 32'h0, 1'b1);
    chk(s_nocin == 32'h5, "R6 cin ignored small", s_nocin, 32'h5);
    chk(s_main == 32'h6, "R1 cin enters bit 0", s_main, 32'h6);

    // R2 boundaries: chain of exactly SPAN and SPAN+1
    drive(32'h0000_1FFF, 32'h1, 1'b0);
    chk(s_main == 32'h0000_2000, "R2 chain of span kept", s_main, 32'h0000_2000);
    drive(32'h0000_3FFF, 32'h1, 1'b0);
    chk(s_main == 32'h0 && m_main, "R2 chain of span+1 dropped", s_main, 32'h0);
    drive(32'h3FFF << 10, 32'h1 << 10, 1'b0);
    chk(s_main == 32'h0, "R2 shifted long chain dropped", s_main, 32'h0);
    chk(s_full == 32'h0100_0000, "R3 shifted chain exact", s_full, 32'h0100_0000);
    compare_all();

    // R5 wrap
    drive(32'h8000_0000, 32'h8000_0000, 1'b0);
    chk(s_full == 32'h0 && !m_full, "R5 no carry-out", s_full, 32'h0);

    // R1 no generate
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
    chk(s_main == 32'hFFFF_FFFF, "R1 propagate only", s_main, 32'hFFFF_FFFF);
    compare_all();

    for (int n = 0; n < 20000; n++) begin
      drive($urandom, $urandom, 1'($urandom));
      compare_all();
      if (m_main) miss++;
    end
    chk(miss <= 40, "R9 random mismatch rate", miss, 32'd40);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule